// File: doc/BRIEF.md
# Decimating Down-Converter Channel

This block turns one stream of real signed samples into a decimated output stream. In complex mode each sample is multiplied by a quadrature oscillator taken from a 48-bit phase accumulator. The product is halved, which is a fixed 6 dB loss. The I and Q products are then averaged over blocks of N samples and one pair is emitted per block. In real mode the mixer is bypassed and the phase is held at zero. The same averaging decimator runs on the raw samples, and Q reads zero.

Configuration is presented on dedicated inputs and applied by a one-cycle load strobe. The decimation factor is N = 2^r, with r from 2 to 7. The smallest allowed r depends on the declared number of active channels. A rejected load leaves the running setting in place and raises a sticky error flag. Results are rounded half away from zero to 16 or 20 bits, sign-extended on 20-bit ports.

Top module: `ddc_channel`

## Requirements
- R1: After synchronous reset `out_valid` and `cfg_err` are 0, `out_i`/`out_q` are 0, and the active setting is real mode, r = 2 (N = 4), 16-bit output, frequency word 0.
- R2: Exactly one output is produced per N accepted samples (`in_valid` high, `cfg_load` low). `out_valid` rises in the cycle after the Nth such sample and lasts one cycle. Idle cycles do not advance the count.
- R3: The channel-count code `cfg_chans` is 0 for one channel (r >= 2), 1 for two (r >= 3), 2 for four (r >= 4), and 3 is reserved. A load that breaks the floor, or uses code 3, changes nothing except setting `cfg_err`. Only reset clears `cfg_err`.
- R4: An accepted load clears the phase, the block sums and the sample count. A sample presented in the load cycle is discarded.
- R5: In real mode the per-sample contribution is the input itself, `out_q` is 0, and the phase accumulator stays 0.
- R6: In complex mode sample x contributes I = floor(x*c / 2^16) and Q = floor(-x*s / 2^16). Here c and s are the cosine and sine of the current phase with amplitude 32767. For quarter-cycle phases they are exactly 32767, 0, -32767 or 0, which gives a half-scale output for a full-scale input.
- R7: With block sum S, the output is round-half-away(S * 2^(W-12) / N), where W is 20 when `cfg_wide` is 1 and 16 otherwise. A 16-bit result is sign-extended to 20 bits.
- R8: In complex mode the frequency word is added to the phase once per accepted sample, including across block boundaries. Sample k after a load uses phase k*F. Only the top 8 phase bits address the oscillator, so low bits of F are truncated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W | Signed input sample |
| cfg_load | input | 1 | Apply configuration inputs this cycle |
| cfg_complex | input | 1 | 1 = complex mixing, 0 = real low-pass |
| cfg_rlog | input | 3 | log2 of the decimation factor |
| cfg_chans | input | 2 | Active channel count code |
| cfg_wide | input | 1 | 1 = 20-bit rounding, 0 = 16-bit |
| cfg_freq | input | ACC_W | Phase increment per sample |
| out_valid | output | 1 | Output pair strobe |
| out_i | output | 20 | In-phase (or real) result |
| out_q | output | 20 | Quadrature result, 0 in real mode |
| cfg_err | output | 1 | Sticky rejected-configuration flag |

## Verification
Several properties are checked on every cycle. Outputs never come back to back, and a load never produces an output. Q stays zero and the phase stays zero in real mode. The phase steps by exactly the frequency word per accepted complex sample. A rejected load leaves the setting alone, and the error flag never falls. Narrow results stay inside the 16-bit range. The averaged and rounded values, the per-phase mixer signs, the ratio floors per channel count, and the discarding of a sample on a load cycle can only be shown by the bench sweeps. These sweeps compare results against arithmetic expectations.

// File: rtl/ddc_channel.sv
module ddc_channel #(
  parameter int IN_W   = 12,
  parameter int LUT_W  = 16,
  parameter int LUT_AB = 6,
  parameter int ACC_W  = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  input  logic             cfg_load,
  input  logic             cfg_complex,
  input  logic [2:0]       cfg_rlog,
  input  logic [1:0]       cfg_chans,
  input  logic             cfg_wide,
  input  logic [ACC_W-1:0] cfg_freq,
  output logic             out_valid,
  output logic [19:0]      out_i,
  output logic [19:0]      out_q,
  output logic             cfg_err
);
  localparam int QN    = 1 << LUT_AB;
  localparam int AMP   = (1 << (LUT_W - 1)) - 1;
  localparam int SUM_W = IN_W + 7;
  localparam int PAD   = 20;
  localparam int V_W   = SUM_W + PAD;
  localparam int P_W   = IN_W + LUT_W;

  function automatic logic signed [LUT_W-1:0] sin_pt(input int k);
    longint kk, qq, num;
    kk  = longint'(k);
    qq  = longint'(QN);
    num = 64'sd102944 * kk * qq * qq * qq * qq
        - 64'sd42152 * kk * kk * kk * qq * qq
        + 64'sd4744 * kk * kk * kk * kk * kk;
    return LUT_W'((num * longint'(AMP)) / (64'sd65536 * qq * qq * qq * qq * qq));
  endfunction

  function automatic logic [19:0] rnd(input logic signed [SUM_W-1:0] s,
                                      input logic [2:0] r, input logic w);
    logic signed [V_W:0] v;
    logic [V_W:0] mag, q;
    int d;
    v   = (V_W+1)'(s) <<< PAD;
    d   = PAD + int'(r) + IN_W - (w ? 20 : 16);
    mag = v[V_W] ? -v : v;
    q   = (mag + ((V_W+1)'(1) << (d - 1))) >> d;
    return v[V_W] ? 20'(-q) : 20'(q);
  endfunction

  logic signed [LUT_W-1:0] lut [0:QN];
  for (genvar k = 0; k <= QN; k++) begin : g_lut
    assign lut[k] = sin_pt(k);
  end

  logic             cmode, wide;
  logic [2:0]       rl;
  logic [ACC_W-1:0] freq, acc;
  logic [6:0]       cnt;
  logic signed [SUM_W-1:0] sum_i, sum_q, nx_i, nx_q;

  wire [1:0]        quad  = acc[ACC_W-1 -: 2];
  wire [LUT_AB:0]   idx   = {1'b0, acc[ACC_W-3 -: LUT_AB]};
  wire [LUT_AB:0]   idx_c = (LUT_AB+1)'(QN) - idx;
  wire signed [LUT_W-1:0] s_a = lut[idx];
  wire signed [LUT_W-1:0] s_b = lut[idx_c];

  logic signed [LUT_W-1:0] cosv, sinv;
  always_comb begin
    case (quad)
      2'd0:    begin sinv = s_a;  cosv = s_b;  end
      2'd1:    begin sinv = s_b;  cosv = -s_a; end
      2'd2:    begin sinv = -s_a; cosv = -s_b; end
      default: begin sinv = -s_b; cosv = s_a;  end
    endcase
  end

  wire signed [P_W-1:0] prod_i = P_W'($signed(in_data)) * P_W'(cosv);
  wire signed [P_W-1:0] prod_q = P_W'($signed(in_data)) * P_W'(-sinv);
  wire signed [P_W-1:0] sh_i   = prod_i >>> LUT_W;
  wire signed [P_W-1:0] sh_q   = prod_q >>> LUT_W;
  wire signed [IN_W-1:0] mix_i = cmode ? sh_i[IN_W-1:0] : $signed(in_data);
  wire signed [IN_W-1:0] mix_q = cmode ? sh_q[IN_W-1:0] : '0;

  assign nx_i = sum_i + SUM_W'(mix_i);
  assign nx_q = sum_q + SUM_W'(mix_q);

  wire last   = {1'b0, cnt} == ((8'd1 << rl) - 8'd1);
  wire cfg_ok = (cfg_chans != 2'd3) && (cfg_rlog >= ({1'b0, cfg_chans} + 3'd2));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmode <= 1'b0; wide <= 1'b0; rl <= 3'd2; freq <= '0; acc <= '0;
      cnt <= '0; sum_i <= '0; sum_q <= '0; cfg_err <= 1'b0;
      out_valid <= 1'b0; out_i <= '0; out_q <= '0;
    end else begin
      out_valid <= 1'b0;
      if (cfg_load) begin
        if (cfg_ok) begin
          cmode <= cfg_complex; wide <= cfg_wide; rl <= cfg_rlog; freq <= cfg_freq;
          acc <= '0; cnt <= '0; sum_i <= '0; sum_q <= '0;
        end else begin
          cfg_err <= 1'b1;
        end
      end else if (in_valid) begin
        acc <= cmode ? acc + freq : '0;
        if (last) begin
          cnt <= '0; sum_i <= '0; sum_q <= '0;
          out_valid <= 1'b1;
          out_i <= rnd(nx_i, rl, wide);
          out_q <= rnd(nx_q, rl, wide);
        end else begin
          cnt <= cnt + 7'd1; sum_i <= nx_i; sum_q <= nx_q;
        end
      end
    end
  end
endmodule

// File: rtl/ddc_channel_chk.sv
module ddc_channel_chk #(
  parameter int ACC_W = 48
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             cfg_load,
  input logic [2:0]       cfg_rlog,
  input logic [1:0]       cfg_chans,
  input logic             out_valid,
  input logic [19:0]      out_i,
  input logic [19:0]      out_q,
  input logic             cfg_err,
  input logic             cmode,
  input logic             wide,
  input logic [2:0]       rl,
  input logic [ACC_W-1:0] acc,
  input logic [ACC_W-1:0] freq
);
  wire bad = (cfg_chans == 2'd3) ||
             (cfg_chans == 2'd0 && cfg_rlog < 3'd2) ||
             (cfg_chans == 2'd1 && cfg_rlog < 3'd3) ||
             (cfg_chans == 2'd2 && cfg_rlog < 3'd4);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !cfg_err)); // R1
  AST_OUT_SPACED: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R2
  AST_BAD_CFG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (cfg_load && bad) |=> (cfg_err && $stable(rl) && $stable(cmode) && $stable(wide))); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err); // R3
  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> !out_valid); // R4
  AST_REAL_Q_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !cmode) |-> (out_q == 20'd0)); // R5
  AST_REAL_PHASE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !cmode |-> (acc == '0)); // R5
  AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !wide) |-> ((out_i[19:15] == 5'h00 || out_i[19:15] == 5'h1f) &&
                              (out_q[19:15] == 5'h00 || out_q[19:15] == 5'h1f))); // R7
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (cmode && in_valid && !cfg_load) |=> (acc == $past(acc) + $past(freq))); // R8
endmodule

bind ddc_channel ddc_channel_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .cfg_load(cfg_load),
  .cfg_rlog(cfg_rlog), .cfg_chans(cfg_chans), .out_valid(out_valid),
  .out_i(out_i), .out_q(out_q), .cfg_err(cfg_err), .cmode(cmode),
  .wide(wide), .rl(rl), .acc(acc), .freq(freq)
);

// File: tb/ddc_channel_test.sv
module ddc_channel_test;
  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, cfg_load = 1'b0, cfg_complex = 1'b0, cfg_wide = 1'b0;
  logic [11:0] in_data = '0;
  logic [2:0] cfg_rlog = 3'd2;
  logic [1:0] cfg_chans = 2'd0;
  logic [47:0] cfg_freq = '0;
  logic out_valid, cfg_err;
  logic [19:0] out_i, out_q;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ddc_channel uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .cfg_load(cfg_load), .cfg_complex(cfg_complex), .cfg_rlog(cfg_rlog),
    .cfg_chans(cfg_chans), .cfg_wide(cfg_wide), .cfg_freq(cfg_freq),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint fdiv(input longint a, input longint b);
    longint q = a / b;
    if ((a % b != 0) && ((a < 0) != (b < 0))) q = q - 1;
    return q;
  endfunction

  function automatic longint expect_out(input longint s, input int r, input bit w);
    longint num = s * (64'sd1 << ((w ? 20 : 16) - 12));
    longint den = 64'sd1 << r;
    if (num >= 0) return (num + den / 2) / den;
    return -((-num + den / 2) / den);
  endfunction

  function automatic longint pattern(input int kind, input int k, input int r);
    case (kind)
      0: return longint'(((k * 73 + r * 19 + 5) % 4096) - 2048);
      1: return 64'sd2047;
      2: return -64'sd2048;
      default: return (k % 2 == 0) ? longint'((k * 13) % 2048) : -longint'((k * 29) % 2049);
    endcase
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic load(input bit cm, input int r, input int ch, input bit w,
                      input logic [47:0] f, input bit with_sample);
    cfg_complex = cm; cfg_rlog = 3'(r); cfg_chans = 2'(ch); cfg_wide = w; cfg_freq = f;
    cfg_load = 1'b1;
    if (with_sample) begin in_valid = 1'b1; in_data = 12'h7ff; end
    tick();
    cfg_load = 1'b0; in_valid = 1'b0;
    chk(!out_valid, "R4 no output after load", longint'(out_valid), 0);
  endtask

  // step: phase advance in quarter cycles per sample (frequency word step * 2^46)
  task automatic run_block(input int r, input bit cm, input bit w, input int kind,
                           input int step, input bit gaps, input string tag);
    int n = 1 << r;
    longint si = 0, sq = 0, x, c, s;
    bit early = 1'b0;
    for (int k = 0; k < n; k++) begin
      x = pattern(kind, k, r);
      case ((k * step) % 4)
        0: begin c = 32767;  s = 0;      end
        1: begin c = 0;      s = 32767;  end
        2: begin c = -32767; s = 0;      end
        default: begin c = 0; s = -32767; end
      endcase
      if (cm) begin
        si += fdiv(x * c, 65536);
        sq += fdiv(-x * s, 65536);
      end else begin
        si += x;
      end
      in_data = 12'(x); in_valid = 1'b1;
      tick();
      in_valid = 1'b0;
      if (k < n - 1 && out_valid) early = 1'b1;
      if (gaps && k % 3 == 1 && k < n - 1) begin
        tick();
        if (out_valid) early = 1'b1;
      end
    end
    chk(!early, {tag, " R2 no early output"}, longint'(early), 0);
    chk(out_valid, {tag, " R2 output after N samples"}, longint'(out_valid), 1);
    chk(longint'($signed(out_i)) == expect_out(si, r, w), {tag, " R7 I value"},
        longint'($signed(out_i)), expect_out(si, r, w));
    chk(longint'($signed(out_q)) == expect_out(sq, r, w), {tag, cm ? " R6 Q value" : " R5 Q zero"},
        longint'($signed(out_q)), expect_out(sq, r, w));
    tick();
    chk(!out_valid, {tag, " R2 single-cycle strobe"}, longint'(out_valid), 0);
  endtask

  initial begin
    repeat (3) tick();
    chk(!out_valid, "R1 out_valid low", longint'(out_valid), 0);
    chk(!cfg_err, "R1 cfg_err low", longint'(cfg_err), 0);
    chk(out_i == 0 && out_q == 0, "R1 outputs zero", longint'(out_i), 0);
    rst = 1'b0;
    tick();
    run_block(2, 1'b0, 1'b0, 0, 0, 1'b0, "R1 default real N=4");

    for (int cm = 0; cm < 2; cm++)
      for (int w = 0; w < 2; w++)
        for (int r = 2; r < 8; r++)
          for (int kind = 0; kind < 4; kind++) begin
            int step = (kind + 1) % 4;
            logic [47:0] f = (48'(step) << 46) + ((kind == 3) ? 48'd5 : 48'd0);
            load(cm[0], r, 0, w[0], f, 1'b0);
            run_block(r, cm[0], w[0], kind, cm ? step : 0, (kind == 0), cm ? "R6 R8 sweep" : "R5 sweep");
            if (cm && kind == 0) run_block(r, 1'b1, w[0], 3, step, 1'b0, "R8 next block");
          end

    load(1'b0, 3, 1, 1'b0, 48'd0, 1'b0);
    chk(!cfg_err, "R3 two channels r=3 accepted", longint'(cfg_err), 0);
    run_block(3, 1'b0, 1'b0, 0, 0, 1'b0, "R3 two ch");
    load(1'b1, 4, 2, 1'b1, 48'h4000_0000_0000, 1'b0);
    chk(!cfg_err, "R3 four channels r=4 accepted", longint'(cfg_err), 0);
    run_block(4, 1'b1, 1'b1, 1, 1, 1'b0, "R3 four ch");
    load(1'b0, 3, 2, 1'b0, 48'd0, 1'b0);
    chk(cfg_err, "R3 four channels r=3 rejected", longint'(cfg_err), 1);
    run_block(4, 1'b1, 1'b1, 2, 1, 1'b0, "R3 kept setting");
    load(1'b0, 7, 3, 1'b0, 48'd0, 1'b0);
    chk(cfg_err, "R3 reserved code rejected", longint'(cfg_err), 1);
    run_block(4, 1'b1, 1'b1, 0, 1, 1'b0, "R3 kept after reserved");
    load(1'b0, 2, 0, 1'b0, 48'd0, 1'b0);
    chk(cfg_err, "R3 error stays set", longint'(cfg_err), 1);
    run_block(2, 1'b0, 1'b0, 1, 0, 1'b0, "R3 later valid load");

    load(1'b0, 3, 0, 1'b0, 48'd0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      in_data = 12'h7ff; in_valid = 1'b1; tick(); in_valid = 1'b0;
    end
    load(1'b0, 3, 0, 1'b0, 48'd0, 1'b1);
    run_block(3, 1'b0, 1'b0, 2, 0, 1'b0, "R4 restart");
    load(1'b1, 2, 0, 1'b0, 48'h4000_0000_0000, 1'b0);
    in_data = 12'h123; in_valid = 1'b1; tick(); in_valid = 1'b0;
    load(1'b1, 2, 0, 1'b0, 48'h4000_0000_0000, 1'b1);
    run_block(2, 1'b1, 1'b0, 0, 1, 1'b0, "R4 phase restart");

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule